// File: doc/BRIEF.md
# Dual Data Pointer with Auto-Step

This block keeps two 16-bit data pointers for an 8051-style core. A shared extension byte widens the active pointer to a 24-bit flat address. The core reads the effective pointer address from `addrOut` for external-data moves, code-table reads and indirect jumps. The block does not touch memory. It also does not add the accumulator for table lookups.

An 8-bit select register controls the block:
- bit 0 picks the active pointer;
- bit 7 turns the step operation into a decrement;
- bit 5 flips bit 0 after each step, load or access strobe.

The `flatMode` input chooses between 16-bit behaviour, where the extension byte is hidden and never changed, and 24-bit behaviour, where the extension byte is address bits 23:16 and takes part in every carry, borrow and load.

All state changes on the clock edge that samples a strobe. The address output is a combinational view of the registered state and of `flatMode`.

Top module: `dptr_pair`

## Requirements
- R1: After reset, both pointers and the extension byte are zero and `selOut` reads 0x04.
- R2: `addrOut[15:0]` shows pointer 1 when `selOut[0]` is 1 and pointer 0 when it is 0.
- R3: A write through `selWrEn` stores `(selWrData & 0xE5) | 0x04`, so bits 1, 3 and 4 always read 0 and bit 2 always reads 1.
- R4: A `stepStb` adds one to the active pointer when `selOut[7]` is 0 and subtracts one when it is 1. The inactive pointer keeps its value.
- R5: With `flatMode` = 1, `addrOut[23:16]` is the extension byte, and a step carries or borrows through all 24 bits, wrapping modulo 2^24 (0xFFFFFF+1 = 0, 0-1 = 0xFFFFFF).
- R6: With `flatMode` = 0, `addrOut[23:16]` is 0, a step wraps modulo 2^16, and the extension byte keeps its value.
- R7: A `loadStb` writes `loadData[15:8]` to the active pointer's high byte and `loadData[7:0]` to its low byte. With `flatMode` = 1 it also writes `loadData[23:16]` to the extension byte; with `flatMode` = 0 the extension byte keeps its value.
- R8: When `selOut[5]` is 1, a step, load or access strobe inverts `selOut[0]` once at the same edge. When `selOut[5]` is 0, an access strobe changes nothing.
- R9: When `loadStb` and `stepStb` come in the same cycle, the load takes effect, no step happens, and `selOut[0]` toggles at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selWrEn | input | 1 | Write strobe for the select register |
| selWrData | input | 8 | Value for the select register, masked before storing |
| flatMode | input | 1 | 1 = 24-bit flat addressing, 0 = 16-bit |
| stepStb | input | 1 | Increment or decrement the active pointer |
| loadStb | input | 1 | Load an immediate value into the active pointer |
| accessStb | input | 1 | Data or code access made through the pointer (toggle only) |
| loadData | input | 24 | Immediate load value: {extension, high, low} |
| addrOut | output | 24 | Effective pointer address |
| selOut | output | 8 | Current select register contents |

## Verification
Every strobe and every select-register write takes effect at the rising edge that samples it. The new pointer, extension byte and select value are therefore visible one cycle after the strobe. `flatMode` affects `addrOut` in the same cycle, with no register in between. The bench drives inputs after a falling edge and waits for the next rising edge. It then waits one more nanosecond and drops the strobes before comparing `addrOut` and `selOut`. Each comparison therefore sees the result of exactly one edge. The checker uses single-cycle `|=>` implications for the same one-edge latency.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int SEL_W = 8;
  localparam int SEL_BIT  = 0;
  localparam int AUTO_BIT = 5;
  localparam int DOWN_BIT = 7;
  localparam logic [SEL_W-1:0] SEL_KEEP  = 8'hE5;
  localparam logic [SEL_W-1:0] SEL_FORCE = 8'h04;
  localparam logic [SEL_W-1:0] SEL_RESET = 8'h04;

  typedef struct packed {
    logic stepEn;
    logic loadEn;
    logic down;
    logic ptrSel;
    logic flat;
  } dpCmd_t;
endpackage

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  input  logic             flatMode,
  input  logic             stepStb,
  input  logic             loadStb,
  input  logic             accessStb,
  output dpCmd_t           cmd,
  output logic [SEL_W-1:0] selOut
);
  logic [SEL_W-1:0] selReg;
  logic [SEL_W-1:0] selNext;
  logic             anyOp;
  logic             flipSel;

  assign anyOp   = stepStb | loadStb | accessStb;
  assign flipSel = anyOp & selReg[AUTO_BIT];

  always_comb begin
    selNext = selReg;
    if (selWrEn)
      selNext = (selWrData & SEL_KEEP) | SEL_FORCE;
    else if (flipSel)
      selNext[SEL_BIT] = ~selReg[SEL_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selReg <= SEL_RESET;
    else       selReg <= selNext;
  end

  // load has priority over step
  always_comb begin
    cmd.loadEn = loadStb;
    cmd.stepEn = stepStb & ~loadStb;
    cmd.down   = selReg[DOWN_BIT];
    cmd.ptrSel = selReg[SEL_BIT];
    cmd.flat   = flatMode;
  end

  assign selOut = selReg;
endmodule

// File: rtl/dptr_path.sv
module dptr_path
  import dptr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W,
  localparam int ADDR_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] loadData,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int NUM_PTR = 2;

  logic [PAIR_W-1:0] ptrQ [NUM_PTR];
  logic [BYTE_W-1:0] extQ;
  logic [PAIR_W-1:0] curPtr;
  logic [ADDR_W-1:0] fullAddr;
  logic [ADDR_W-1:0] stepped;

  assign curPtr   = ptrQ[cmd.ptrSel];
  assign fullAddr = {extQ, curPtr};
  // low PAIR_W bits equal a 16-bit wrap; upper byte used only in flat mode
  assign stepped  = cmd.down ? fullAddr - ADDR_W'(1) : fullAddr + ADDR_W'(1);

  for (genvar g = 0; g < NUM_PTR; g++) begin : gen_ptr
    logic [PAIR_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (cmd.ptrSel == 1'(g)) begin
        if (cmd.loadEn)      q <= loadData[PAIR_W-1:0];
        else if (cmd.stepEn) q <= stepped[PAIR_W-1:0];
      end
    end
    assign ptrQ[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      extQ <= '0;
    else if (cmd.flat) begin
      if (cmd.loadEn)      extQ <= loadData[ADDR_W-1:PAIR_W];
      else if (cmd.stepEn) extQ <= stepped[ADDR_W-1:PAIR_W];
    end
  end

  assign addrOut = cmd.flat ? fullAddr : {{BYTE_W{1'b0}}, curPtr};
endmodule

// File: rtl/dptr_pair.sv
module dptr_pair
  import dptr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selWrEn,
  input  logic [SEL_W-1:0]  selWrData,
  input  logic              flatMode,
  input  logic              stepStb,
  input  logic              loadStb,
  input  logic              accessStb,
  input  logic [ADDR_W-1:0] loadData,
  output logic [ADDR_W-1:0] addrOut,
  output logic [SEL_W-1:0]  selOut
);
  dpCmd_t cmd;

  dptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selWrData(selWrData),
    .flatMode(flatMode), .stepStb(stepStb), .loadStb(loadStb),
    .accessStb(accessStb), .cmd(cmd), .selOut(selOut)
  );

  dptr_path #(.BYTE_W(BYTE_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadData(loadData), .addrOut(addrOut)
  );
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk
  import dptr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 3 * BYTE_W,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              selWrEn,
  input logic [SEL_W-1:0]  selWrData,
  input logic              flatMode,
  input logic              stepStb,
  input logic              loadStb,
  input logic              accessStb,
  input logic [ADDR_W-1:0] loadData,
  input logic [ADDR_W-1:0] addrOut,
  input logic [SEL_W-1:0]  selOut
);
  p_sel_fixed_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    (selOut & 8'h1E) == 8'h04);

  p_sel_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    selWrEn |=> selOut == (($past(selWrData) & 8'hE5) | 8'h04));

  p_access_toggle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!selWrEn && accessStb && selOut[AUTO_BIT]) |=> selOut[SEL_BIT] != $past(selOut[SEL_BIT]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!selWrEn && !stepStb && !loadStb && !accessStb) |=> $stable(selOut));

  p_load_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && !selWrEn && !selOut[AUTO_BIT]) |=> addrOut[PAIR_W-1:0] == $past(loadData[PAIR_W-1:0]));

  p_step16_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stepStb && !loadStb && !selWrEn && !selOut[AUTO_BIT]) |=>
      addrOut[PAIR_W-1:0] == PAIR_W'($past(addrOut[PAIR_W-1:0]) +
        ($past(selOut[DOWN_BIT]) ? {PAIR_W{1'b1}} : PAIR_W'(1))));

  p_ext_hidden_r6: assert property (@(posedge clk) disable iff (!rstN)
    !flatMode |-> addrOut[ADDR_W-1:PAIR_W] == '0);
endmodule

bind dptr_pair dptr_pair_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selWrData(selWrData),
  .flatMode(flatMode), .stepStb(stepStb), .loadStb(loadStb),
  .accessStb(accessStb), .loadData(loadData), .addrOut(addrOut), .selOut(selOut)
);

// File: tb/sim_dptr_pair.sv
`timescale 1ns/100ps
module sim_dptr_pair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selWrEn = 1'b0;
  logic [7:0]  selWrData = '0;
  logic        flatMode = 1'b0;
  logic        stepStb = 1'b0;
  logic        loadStb = 1'b0;
  logic        accessStb = 1'b0;
  logic [23:0] loadData = '0;
  logic [23:0] addrOut;
  logic [7:0]  selOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dptr_pair u0 (
    .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selWrData(selWrData),
    .flatMode(flatMode), .stepStb(stepStb), .loadStb(loadStb),
    .accessStb(accessStb), .loadData(loadData), .addrOut(addrOut), .selOut(selOut)
  );

  // op codes: 0 idle, 1 select write, 2 step, 3 load, 4 access, 5 load+step
  // vector: {op[2:0], flat, data[23:0], expAddr[23:0], expSel[7:0]}
  localparam int NV = 18;
  localparam logic [59:0] VEC [NV] = '{
    {3'd3, 1'b0, 24'h1234FF, 24'h0034FF, 8'h04}, // R7 16-bit load, ext untouched
    {3'd2, 1'b0, 24'h000000, 24'h003500, 8'h04}, // R4 step up
    {3'd1, 1'b0, 24'h0000FF, 24'h000000, 8'hE5}, // R3 mask, R2 ptr1 chosen
    {3'd2, 1'b0, 24'h000000, 24'h003500, 8'hE4}, // R4 down wrap ptr1, R8 toggle
    {3'd4, 1'b0, 24'h000000, 24'h00FFFF, 8'hE5}, // R8 access toggle, R6 wrap
    {3'd1, 1'b0, 24'h000001, 24'h00FFFF, 8'h05}, // R3
    {3'd2, 1'b1, 24'h000000, 24'h010000, 8'h05}, // R5 carry into ext
    {3'd3, 1'b1, 24'hABCDEF, 24'hABCDEF, 8'h05}, // R7 flat load
    {3'd0, 1'b0, 24'h000000, 24'h00CDEF, 8'h05}, // R6 ext hidden
    {3'd1, 1'b1, 24'h000000, 24'hAB3500, 8'h04}, // R2 ptr0 kept value
    {3'd1, 1'b1, 24'h000080, 24'hAB3500, 8'h84}, // R3
    {3'd2, 1'b1, 24'h000000, 24'hAB34FF, 8'h84}, // R4 decrement
    {3'd3, 1'b1, 24'h000000, 24'h000000, 8'h84}, // R7
    {3'd2, 1'b1, 24'h000000, 24'hFFFFFF, 8'h84}, // R5 borrow wraps 2^24
    {3'd4, 1'b1, 24'h000000, 24'hFFFFFF, 8'h84}, // R8 access no effect
    {3'd0, 1'b0, 24'h000000, 24'h00FFFF, 8'h84}, // R6
    {3'd2, 1'b0, 24'h000000, 24'h00FFFE, 8'h84}, // R6 16-bit step
    {3'd0, 1'b1, 24'h000000, 24'hFFFFFE, 8'h84}  // R6 ext kept by 16-bit step
  };

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic flat, input logic [23:0] data);
    @(negedge clk);
    flatMode  = flat;
    loadData  = data;
    selWrData = data[7:0];
    selWrEn   = (op == 3'd1);
    stepStb   = (op == 3'd2) || (op == 3'd5);
    loadStb   = (op == 3'd3) || (op == 3'd5);
    accessStb = (op == 3'd4);
    @(posedge clk);
    #1;
    selWrEn = 1'b0; stepStb = 1'b0; loadStb = 1'b0; accessStb = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 addr", addrOut, 24'h000000);
    check("R1 sel", {16'h0, selOut}, 24'h000004);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][59:57], VEC[i][56], VEC[i][55:32]);
      check($sformatf("vec%0d addr", i), addrOut, VEC[i][31:8]);
      check($sformatf("vec%0d sel", i), {16'h0, selOut}, {16'h0, VEC[i][7:0]});
    end

    // R1 reset mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    flatMode = 1'b1;
    #1;
    check("R1 addr after reset", addrOut, 24'h000000);
    check("R1 sel after reset", {16'h0, selOut}, 24'h000004);
    @(negedge clk);
    rstN = 1'b1;

    // R6: 16-bit wrap does not carry into ext
    apply(3'd3, 1'b1, 24'h07FFFF);
    check("R7 flat load", addrOut, 24'h07FFFF);
    apply(3'd2, 1'b0, 24'h0);
    check("R6 wrap16", addrOut, 24'h000000);
    apply(3'd0, 1'b1, 24'h0);
    check("R6 ext kept", addrOut, 24'h070000);

    // R9: load and step together, auto-toggle once
    apply(3'd1, 1'b0, 24'h000020);
    check("R3 sel auto", {16'h0, selOut}, 24'h000024);
    apply(3'd5, 1'b0, 24'h001111);
    check("R9 single toggle", {16'h0, selOut}, 24'h000025);
    check("R9 ptr1 untouched", addrOut, 24'h000000);
    apply(3'd1, 1'b0, 24'h000024);
    check("R9 load wins", addrOut, 24'h001111);

    finish_run();
  end
endmodule